// File: doc/BRIEF.md
# Battery Charge Controller

This block decides when an external battery charger should run and drives three status indicators and a fan request. It takes battery voltage and temperature readings as unsigned ADC codes. A single-cycle strobe marks each pair of readings as valid. Each valid voltage reading is sorted into one of four bands: low, normal, high and critical. The bands are set by three programmable thresholds, so the controller only updates its view of the battery when a new sample arrives.

The charger is switched on as soon as the battery reads low. It then stays on through the normal band, which gives hysteresis. Above the high threshold the charger is released, but only after a programmable number of consecutive high samples. A separate critical threshold releases it at once. A fan request is raised while the temperature reading exceeds its own threshold.

The indicators either blink or stay steady. All blinking LEDs share one free-running divider, so they flash in step. The divider's period is programmable.

Top module: `batt_charge_ctrl`

## Requirements
- R1: After synchronous reset `chg_en`, `fan_req` and all three LEDs are 0, and they stay 0 until the first cycle with `smp_vld` high; reset taken while charging turns the charger off on the next cycle.
- R2: Voltage bands: low when code < `thr_low`, high when code > `thr_high`, critical when code > `thr_crit`, otherwise normal; a code equal to a threshold is not beyond it. Inputs are evaluated only in cycles with `smp_vld` high; in other cycles they change nothing.
- R3: A low sample turns `chg_en` on in the cycle after the strobe, from any state.
- R4: While charging, normal-band samples keep `chg_en` on.
- R5: While charging, `chg_en` drops after the (`off_delay`+1)-th consecutive high (non-critical) sample; any low or normal sample in between restarts the count. With `off_delay` = 0 the first high sample releases it.
- R6: A critical sample drops `chg_en` in the cycle after the strobe, whatever the delay count.
- R7: `led_hv` blinks while the last sample was high or critical and is 0 otherwise.
- R8: After the first sample `led_good` blinks while `chg_en` is 1 and is steady 1 while `chg_en` is 0.
- R9: When the last temperature code was > `thr_fan`, `fan_req` is 1 and `led_fan` blinks; otherwise both are 0 (equal is not above).
- R10: Blinking means equal to a shared phase bit. The phase is 0 after reset and toggles once every `blink_period`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Marks voltage and temperature codes as a valid sample |
| volt_code | input | ADC_W | Battery voltage ADC code |
| temp_code | input | ADC_W | Temperature ADC code |
| thr_low | input | ADC_W | Low-battery threshold |
| thr_high | input | ADC_W | High threshold for delayed turn-off |
| thr_crit | input | ADC_W | Critical threshold for immediate turn-off |
| thr_fan | input | ADC_W | Fan temperature threshold |
| off_delay | input | DLY_W | Extra high samples tolerated before turn-off |
| blink_period | input | DIV_W | Blink divider terminal count |
| chg_en | output | 1 | Charger enable |
| fan_req | output | 1 | Fan slow-run request |
| led_hv | output | 1 | High-voltage indicator |
| led_good | output | 1 | Good-voltage indicator |
| led_fan | output | 1 | Fan / temperature indicator |

## Verification
The bench builds the block with `DLY_W` = 3 and `DIV_W` = 4. It uses a blink terminal count of 5, so the phase toggles every six cycles and several blink phases fall inside each short test. The turn-off delay is set to 2, which fits a full delay run and a restart of the count in a few samples, and it is later set to 0 to check the no-delay case. The threshold values sit just around each sample code, so the bench checks both equal-to-threshold and one-past-threshold readings for the voltage and temperature comparisons.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    typedef enum logic [1:0] {
        BAND_NORM = 2'd0,
        BAND_LOW  = 2'd1,
        BAND_HIGH = 2'd2,
        BAND_CRIT = 2'd3
    } band_e;

    typedef enum logic [1:0] {
        CS_INIT   = 2'd0,
        CS_IDLE   = 2'd1,
        CS_CHARGE = 2'd2
    } chg_state_e;
endpackage

// File: rtl/bcc_band_cmp.sv
module bcc_band_cmp
    import bcc_pkg::*;
#(
    parameter int ADC_W = 10
) (
    input  logic [ADC_W-1:0] code,
    input  logic [ADC_W-1:0] thr_low,
    input  logic [ADC_W-1:0] thr_high,
    input  logic [ADC_W-1:0] thr_crit,
    output band_e            band
);
    // Critical wins over high; low only applies when not above either limit.
    always_comb begin
        if (code > thr_crit)      band = BAND_CRIT;
        else if (code > thr_high) band = BAND_HIGH;
        else if (code < thr_low)  band = BAND_LOW;
        else                      band = BAND_NORM;
    end
endmodule

// File: rtl/bcc_blink_div.sv
module bcc_blink_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] period,
    output logic             phase
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt >= period) begin
            div_d.cnt = '0;
            div_d.ph  = ~div_q.ph;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign phase = div_q.ph;
endmodule

// File: rtl/bcc_charge_fsm.sv
module bcc_charge_fsm
    import bcc_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  band_e            band,
    input  logic [DLY_W-1:0] off_delay,
    output logic             chg_on
);
    typedef struct packed {
        chg_state_e       st;
        logic [DLY_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (smp_vld) begin
            unique case (fsm_q.st)
                CS_CHARGE: begin
                    unique case (band)
                        BAND_CRIT: begin
                            fsm_d.st  = CS_IDLE;
                            fsm_d.cnt = '0;
                        end
                        BAND_HIGH: begin
                            if (fsm_q.cnt >= off_delay) begin
                                fsm_d.st  = CS_IDLE;
                                fsm_d.cnt = '0;
                            end else begin
                                fsm_d.cnt = fsm_q.cnt + 1'b1;
                            end
                        end
                        default: fsm_d.cnt = '0;
                    endcase
                end
                default: begin
                    fsm_d.cnt = '0;
                    fsm_d.st  = (band == BAND_LOW) ? CS_CHARGE : CS_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fsm_q <= '{st: CS_INIT, cnt: '0};
        else     fsm_q <= fsm_d;
    end

    assign chg_on = (fsm_q.st == CS_CHARGE);
endmodule

// File: rtl/batt_charge_ctrl.sv
module batt_charge_ctrl
    import bcc_pkg::*;
#(
    parameter int ADC_W = 10,
    parameter int DLY_W = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic [ADC_W-1:0] volt_code,
    input  logic [ADC_W-1:0] temp_code,
    input  logic [ADC_W-1:0] thr_low,
    input  logic [ADC_W-1:0] thr_high,
    input  logic [ADC_W-1:0] thr_crit,
    input  logic [ADC_W-1:0] thr_fan,
    input  logic [DLY_W-1:0] off_delay,
    input  logic [DIV_W-1:0] blink_period,
    output logic             chg_en,
    output logic             fan_req,
    output logic             led_hv,
    output logic             led_good,
    output logic             led_fan
);
    typedef struct packed {
        logic  seen;
        band_e band;
        logic  hot;
    } stat_t;

    band_e band_now;
    logic  phase;
    logic  chg_on;
    stat_t stat_d, stat_q;

    bcc_band_cmp #(.ADC_W(ADC_W)) i_band (
        .code     (volt_code),
        .thr_low  (thr_low),
        .thr_high (thr_high),
        .thr_crit (thr_crit),
        .band     (band_now)
    );

    bcc_blink_div #(.DIV_W(DIV_W)) i_div (
        .clk    (clk),
        .rst    (rst),
        .period (blink_period),
        .phase  (phase)
    );

    bcc_charge_fsm #(.DLY_W(DLY_W)) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .band      (band_now),
        .off_delay (off_delay),
        .chg_on    (chg_on)
    );

    // Snapshot of the last valid sample, used for the indicators.
    always_comb begin
        stat_d = stat_q;
        if (smp_vld) begin
            stat_d.seen = 1'b1;
            stat_d.band = band_now;
            stat_d.hot  = (temp_code > thr_fan);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '{seen: 1'b0, band: BAND_NORM, hot: 1'b0};
        else     stat_q <= stat_d;
    end

    logic above_high;
    assign above_high = (stat_q.band == BAND_HIGH) || (stat_q.band == BAND_CRIT);

    assign chg_en   = chg_on;
    assign fan_req  = stat_q.seen & stat_q.hot;
    assign led_fan  = stat_q.seen & stat_q.hot & phase;
    assign led_hv   = stat_q.seen & above_high & phase;
    assign led_good = stat_q.seen & (chg_on ? phase : 1'b1);
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
    parameter int ADC_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic [ADC_W-1:0] volt_code,
    input logic [ADC_W-1:0] temp_code,
    input logic [ADC_W-1:0] thr_low,
    input logic [ADC_W-1:0] thr_high,
    input logic [ADC_W-1:0] thr_crit,
    input logic [ADC_W-1:0] thr_fan,
    input logic             chg_en,
    input logic             fan_req,
    input logic             led_hv,
    input logic             led_good,
    input logic             led_fan
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(smp_vld)) |->
            (!chg_en && !fan_req && !led_hv && !led_good && !led_fan));

    a_r2_no_strobe_no_change: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(chg_en) && $stable(fan_req)));

    a_r3_low_enables: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && volt_code < thr_low) |=> chg_en);

    a_r4_hold_in_normal: assert property (@(posedge clk) disable iff (rst)
        (chg_en && smp_vld && volt_code >= thr_low && volt_code <= thr_high) |=> chg_en);

    a_r6_crit_cuts: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && volt_code > thr_crit) |=> !chg_en);

    a_r9_fan_request: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> (fan_req == (temp_code > thr_fan)) or !$past(smp_vld));
endmodule

bind batt_charge_ctrl bcc_checker #(.ADC_W(ADC_W)) i_bcc_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .volt_code (volt_code),
    .temp_code (temp_code),
    .thr_low   (thr_low),
    .thr_high  (thr_high),
    .thr_crit  (thr_crit),
    .thr_fan   (thr_fan),
    .chg_en    (chg_en),
    .fan_req   (fan_req),
    .led_hv    (led_hv),
    .led_good  (led_good),
    .led_fan   (led_fan)
);

// File: tb/test_batt_charge_ctrl.sv
`timescale 1ns/1ps
module test_batt_charge_ctrl;
    localparam int ADC_W = 10;
    localparam int DLY_W = 3;
    localparam int DIV_W = 4;
    localparam int NV    = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_vld = 1'b0;
    logic [ADC_W-1:0] volt_code = '0;
    logic [ADC_W-1:0] temp_code = '0;
    logic [ADC_W-1:0] thr_low  = 10'd600;
    logic [ADC_W-1:0] thr_high = 10'd700;
    logic [ADC_W-1:0] thr_crit = 10'd800;
    logic [ADC_W-1:0] thr_fan  = 10'd300;
    logic [DLY_W-1:0] off_delay = 3'd2;
    logic [DIV_W-1:0] blink_period = 4'd5;
    logic chg_en, fan_req, led_hv, led_good, led_fan;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    batt_charge_ctrl #(.ADC_W(ADC_W), .DLY_W(DLY_W), .DIV_W(DIV_W)) i_batt_charge_ctrl (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .volt_code(volt_code), .temp_code(temp_code),
        .thr_low(thr_low), .thr_high(thr_high), .thr_crit(thr_crit), .thr_fan(thr_fan),
        .off_delay(off_delay), .blink_period(blink_period),
        .chg_en(chg_en), .fan_req(fan_req),
        .led_hv(led_hv), .led_good(led_good), .led_fan(led_fan)
    );

    // Expected blink phase from R10: 0 at reset, toggles every blink_period+1 cycles.
    logic [DIV_W-1:0] m_cnt;
    logic             m_ph;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0;
            m_ph  <= 1'b0;
        end else if (m_cnt == blink_period) begin
            m_cnt <= '0;
            m_ph  <= ~m_ph;
        end else begin
            m_cnt <= m_cnt + 1'b1;
        end
    end

    // Vector: volt, temp, chg, hv mode, good mode, fan (mode 0 off, 1 on, 2 blink)
    localparam logic [25:0] VEC [NV] = '{
        {10'd650, 10'd200, 1'b0, 2'd0, 2'd1, 1'b0},  // R2 normal, stays off
        {10'd550, 10'd200, 1'b1, 2'd0, 2'd2, 1'b0},  // R3 low -> on
        {10'd650, 10'd200, 1'b1, 2'd0, 2'd2, 1'b0},  // R4 hysteresis
        {10'd720, 10'd350, 1'b1, 2'd2, 2'd2, 1'b1},  // R5 high #1, R9 hot
        {10'd720, 10'd350, 1'b1, 2'd2, 2'd2, 1'b1},  // R5 high #2
        {10'd650, 10'd200, 1'b1, 2'd0, 2'd2, 1'b0},  // R5 count restart
        {10'd720, 10'd200, 1'b1, 2'd2, 2'd2, 1'b0},  // R5 high #1
        {10'd720, 10'd200, 1'b1, 2'd2, 2'd2, 1'b0},  // R5 high #2
        {10'd720, 10'd200, 1'b0, 2'd2, 2'd1, 1'b0},  // R5 high #3 -> off, R8 steady
        {10'd650, 10'd300, 1'b0, 2'd0, 2'd1, 1'b0},  // R9 equal temp not hot
        {10'd720, 10'd301, 1'b0, 2'd2, 2'd1, 1'b1},  // R7 hv blink while off, R9
        {10'd550, 10'd200, 1'b1, 2'd0, 2'd2, 1'b0},  // R3
        {10'd850, 10'd200, 1'b0, 2'd2, 2'd1, 1'b0},  // R6 crit immediate
        {10'd600, 10'd200, 1'b0, 2'd0, 2'd1, 1'b0},  // R2 equal low not low
        {10'd599, 10'd200, 1'b1, 2'd0, 2'd2, 1'b0},  // R2 one below low
        {10'd800, 10'd200, 1'b1, 2'd2, 2'd2, 1'b0},  // R2 equal crit is only high
        {10'd801, 10'd200, 1'b0, 2'd2, 2'd1, 1'b0}   // R6 one past crit
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic mode_val(input logic [1:0] m);
        return (m == 2'd0) ? 1'b0 : (m == 2'd1) ? 1'b1 : m_ph;
    endfunction

    task automatic strobe(input logic [ADC_W-1:0] v, input logic [ADC_W-1:0] t);
        @(negedge clk);
        volt_code = v;
        temp_code = t;
        smp_vld   = 1'b1;
        @(negedge clk);
        smp_vld   = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, nothing before the first strobe
        chk("R1 chg_en", chg_en, 1'b0);
        chk("R1 fan_req", fan_req, 1'b0);
        chk("R1 led_hv", led_hv, 1'b0);
        chk("R1 led_good", led_good, 1'b0);
        chk("R1 led_fan", led_fan, 1'b0);
        volt_code = 10'd100;
        temp_code = 10'd900;
        repeat (8) @(negedge clk);
        chk("R1 no strobe chg_en", chg_en, 1'b0);
        chk("R1 no strobe led_good", led_good, 1'b0);

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][25:16], VEC[i][15:6]);
            for (int k = 0; k < 3; k++) begin
                chk($sformatf("R5 vec%0d chg_en", i), chg_en, VEC[i][5]);
                chk($sformatf("R7 vec%0d led_hv", i), led_hv, mode_val(VEC[i][4:3]));
                chk($sformatf("R8 vec%0d led_good", i), led_good, mode_val(VEC[i][2:1]));
                chk($sformatf("R9 vec%0d fan_req", i), fan_req, VEC[i][0]);
                chk($sformatf("R10 vec%0d led_fan", i), led_fan, VEC[i][0] & m_ph);
                if (k < i % 3) @(negedge clk);
            end
        end

        // R2: inputs without strobe are ignored (state is OFF, last sample 801/200)
        volt_code = 10'd100;
        temp_code = 10'd900;
        repeat (6) @(negedge clk);
        chk("R2 ignored volt chg_en", chg_en, 1'b0);
        chk("R2 ignored temp fan_req", fan_req, 1'b0);
        chk("R2 ignored led_good", led_good, 1'b1);

        // R10: led_hv toggles exactly twice over 12 cycles with period 5
        strobe(10'd750, 10'd200);
        begin
            logic prev;
            int   flips;
            prev  = led_hv;
            flips = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (led_hv !== prev) flips++;
                prev = led_hv;
            end
            total++;
            if (flips != 2) begin
                bad++;
                $display("FAIL R10 toggle count actual=%0d expected=2", flips);
            end
        end

        // R5: zero delay releases on the first high sample
        off_delay = 3'd0;
        strobe(10'd500, 10'd200);
        chk("R3 zero-delay setup chg_en", chg_en, 1'b1);
        strobe(10'd701, 10'd200);
        chk("R5 zero delay chg_en", chg_en, 1'b0);

        // R1: reset while charging
        strobe(10'd500, 10'd400);
        chk("R9 hot before reset", fan_req, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-run chg_en", chg_en, 1'b0);
        chk("R1 reset mid-run fan_req", fan_req, 1'b0);
        chk("R1 reset mid-run led_good", led_good, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule